// File: doc/BRIEF.md
# Oversampled Command Frame Receiver

This block sits behind the front end of a proximity-card tag that listens to commands from a reader. Each sample is a single demodulated bit, and there are four samples per elementary time unit (bit period). The samples arrive through a valid strobe, and any number of idle clock cycles may separate them. The receiver looks for the long low start-of-frame marker and checks its length. It then finds the falling edge that opens each character and samples every bit in the middle of its period. Each character is assembled as a ten-bit word, one start bit, eight data bits and one stop bit, and the framing bits are checked.

Good characters come out one byte at a time with a single-cycle strobe. A character whose ten bits are all zero is the end-of-frame marker. When it follows at least one byte, the receiver pulses frame-done and reports the byte count of the frame. Framing violations, an over-long idle gap between characters, and a frame that reaches the configured maximum byte count all raise a one-cycle error pulse, and the receiver then hunts for the next start-of-frame. CRC checking and command decoding belong to the logic downstream.

Top module: `cmd_frame_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `byte_vld`, `frame_done` and `rx_err` are low, `rx_active` is low and `frame_len` is 0. A reset in the middle of a frame drops `rx_active`.
- R2: Only cycles with `smp_vld` high advance the receiver. `smp_bit` is ignored in all other cycles, and any number of idle cycles between samples leaves the result unchanged.
- R3: In the idle state, a low sample starts the start-of-frame phase at sample phase 0. Every bit is judged on its third sample, which is phase 2 of 0..3. A high mid-sample after 10, 11 or 12 low mid-samples accepts the start-of-frame and raises `rx_active` in the following cycle.
- R4: A high mid-sample after fewer than 10 low mid-samples pulses `rx_err` and returns the receiver to idle with `rx_active` low.
- R5: The 13th consecutive low mid-sample of the start-of-frame phase pulses `rx_err` and returns the receiver to idle.
- R6: While a start bit is awaited, up to 25 consecutive high samples are tolerated. The 26th pulses `rx_err` and returns the receiver to idle. A low sample opens a character at phase 0.
- R7: A character is ten mid-samples: a start bit that must be 0, eight data bits sent least significant first, and a stop bit that must be 1. A valid character gives a one-cycle `byte_vld` pulse with the byte on `byte_data`.
- R8: A character of ten zero mid-samples that follows at least one byte ends the frame. `frame_done` pulses with `frame_len` equal to the byte count, and `rx_active` falls. This decision is taken on the mid-sample of the tenth zero bit.
- R9: An all-zero character received before any byte ends the attempt silently, with no `frame_done` and no `rx_err`, and returns the receiver to idle.
- R10: Any other character, neither valid nor all zero, pulses `rx_err` and returns the receiver to idle without `frame_done`.
- R11: The byte that brings the count to MAX_BYTES is still delivered on `byte_vld`, together with `rx_err` in the same cycle. `rx_active` falls and that frame never signals `frame_done`.
- R12: `frame_done` and `rx_err` never pulse together. Each event produces exactly one pulse of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe |
| smp_bit | input | 1 | Demodulated sample value |
| byte_vld | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | DATA_W | Received byte |
| frame_done | output | 1 | One-cycle pulse at a valid end of frame |
| frame_len | output | clog2(MAX_BYTES+1) | Byte count of the completed frame |
| rx_err | output | 1 | One-cycle error pulse |
| rx_active | output | 1 | High from start-of-frame acceptance until end of frame or error |

## Verification
Assertions check the following on every cycle:
- no output pulse follows a cycle without a sample;
- `frame_done` and `rx_err` are exclusive;
- a reported length is never zero and never reaches MAX_BYTES;
- `rx_active` rises only on a high sample;
- `rx_active` falls without an error only on a low sample;
- a byte that leaves the active state carries an error.

Only the bench scenarios show the rest: the exact start-of-frame length window, the 25/26-sample gap boundary, the decoded byte values over the whole byte range, the silent empty frame, and overflow at the configured maximum.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SOF  = 2'd1,
      ST_GAP  = 2'd2,
      ST_CHAR = 2'd3
   } rx_state_t;
endpackage

// File: rtl/cfr_phase.sv
// Sample-phase counter: wraps every OVS samples, flags the mid-bit sample.
module cfr_phase #(
   parameter int OVS = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic step,
   output logic mid
);
   localparam int PW  = (OVS > 2) ? $clog2(OVS) : 1;
   localparam int MID = OVS / 2;

   logic [PW-1:0] ph;
   logic [PW-1:0] ph_inc;

   generate
      if (OVS < 2 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("cfr_phase: OVS must be even and at least 2");
      end
      if ((OVS & (OVS - 1)) == 0) begin : g_pow2
         assign ph_inc = ph + PW'(1);
      end else begin : g_wrap
         assign ph_inc = (ph == PW'(OVS - 1)) ? '0 : ph + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr) ph <= '0;
      else if (step)  ph <= ph_inc;
   end

   assign mid = step && !clr && (ph_inc == PW'(MID));
endmodule

// File: rtl/cfr_run_ctr.sv
// Saturation-free run counter with clear priority.
module cfr_run_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   generate
      if (W < 1) begin : g_bad_w
         $error("cfr_run_ctr: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr) cnt <= '0;
      else if (inc)   cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/cfr_char_shift.sv
// Right-shifting character register; new bits enter at the top.
module cfr_char_shift #(
   parameter int CHAR_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              shift,
   input  logic              din,
   output logic [CHAR_W-1:0] chr_nx,
   output logic              last
);
   localparam int CNW = $clog2(CHAR_W + 1);

   logic [CHAR_W-1:0] chr;
   logic [CNW-1:0]    cnt;

   generate
      if (CHAR_W < 3) begin : g_bad_w
         $error("cfr_char_shift: CHAR_W must be at least 3");
      end
   endgenerate

   assign chr_nx = {din, chr[CHAR_W-1:1]};
   assign last   = shift && (cnt == CNW'(CHAR_W - 1));

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         chr <= '0;
         cnt <= '0;
      end else if (shift) begin
         chr <= chr_nx;
         cnt <= cnt + CNW'(1);
      end
   end

   a_r7_bit_count_bound : assert property (@(posedge clk) disable iff (rst)
      cnt <= CNW'(CHAR_W));
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx #(
   parameter int OVS       = 4,
   parameter int DATA_W    = 8,
   parameter int SOF_MIN   = 10,
   parameter int SOF_MAX   = 12,
   parameter int GAP_MAX   = 25,
   parameter int MAX_BYTES = 256
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             smp_vld,
   input  logic                             smp_bit,
   output logic                             byte_vld,
   output logic [DATA_W-1:0]                byte_data,
   output logic                             frame_done,
   output logic [$clog2(MAX_BYTES+1)-1:0]   frame_len,
   output logic                             rx_err,
   output logic                             rx_active
);
   import cfr_pkg::*;

   localparam int CHAR_W = DATA_W + 2;
   localparam int LW     = $clog2(MAX_BYTES + 1);
   localparam int SW     = $clog2(SOF_MAX + 2);
   localparam int GW     = $clog2(GAP_MAX + 2);

   generate
      if (SOF_MIN < 1 || SOF_MIN > SOF_MAX) begin : g_bad_sof
         $error("cmd_frame_rx: need 1 <= SOF_MIN <= SOF_MAX");
      end
      if (GAP_MAX < 1) begin : g_bad_gap
         $error("cmd_frame_rx: GAP_MAX must be positive");
      end
      if (MAX_BYTES < 2) begin : g_bad_max
         $error("cmd_frame_rx: MAX_BYTES must be at least 2");
      end
   endgenerate

   rx_state_t st, st_n;
   logic [LW-1:0] bcnt, bcnt_n, bcnt_inc;
   logic [SW-1:0] sof_cnt, sof_nx;
   logic [GW-1:0] gap_cnt, gap_nx;
   logic [CHAR_W-1:0] chr_nx;
   logic mid, last;
   logic ph_clr, ph_step, sof_clr, sof_inc, gap_clr, gap_inc, sh_clr, sh_go;
   logic byte_go, done_go, err_go;

   cfr_phase #(.OVS(OVS)) u_phase (
      .clk(clk), .rst(rst), .clr(ph_clr), .step(ph_step), .mid(mid));

   cfr_run_ctr #(.W(SW)) u_sof_ctr (
      .clk(clk), .rst(rst), .clr(sof_clr), .inc(sof_inc), .cnt(sof_cnt));

   cfr_run_ctr #(.W(GW)) u_gap_ctr (
      .clk(clk), .rst(rst), .clr(gap_clr), .inc(gap_inc), .cnt(gap_cnt));

   cfr_char_shift #(.CHAR_W(CHAR_W)) u_shift (
      .clk(clk), .rst(rst), .clr(sh_clr), .shift(sh_go), .din(smp_bit),
      .chr_nx(chr_nx), .last(last));

   assign sof_nx   = sof_cnt + SW'(1);
   assign gap_nx   = gap_cnt + GW'(1);
   assign bcnt_inc = bcnt + LW'(1);

   always_comb begin
      st_n    = st;
      bcnt_n  = bcnt;
      ph_clr  = 1'b0;
      ph_step = 1'b0;
      sof_clr = 1'b0;
      sof_inc = 1'b0;
      gap_clr = 1'b0;
      gap_inc = 1'b0;
      sh_clr  = 1'b0;
      sh_go   = 1'b0;
      byte_go = 1'b0;
      done_go = 1'b0;
      err_go  = 1'b0;
      if (smp_vld) begin
         case (st)
            ST_IDLE: begin
               if (!smp_bit) begin
                  st_n    = ST_SOF;
                  ph_clr  = 1'b1;
                  sof_clr = 1'b1;
               end
            end
            ST_SOF: begin
               ph_step = 1'b1;
               if (mid) begin
                  if (smp_bit) begin
                     if (sof_cnt >= SW'(SOF_MIN)) begin
                        st_n    = ST_GAP;
                        gap_clr = 1'b1;
                        bcnt_n  = '0;
                     end else begin
                        st_n   = ST_IDLE;
                        err_go = 1'b1;
                     end
                  end else if (sof_nx > SW'(SOF_MAX)) begin
                     st_n   = ST_IDLE;
                     err_go = 1'b1;
                  end else begin
                     sof_inc = 1'b1;
                  end
               end
            end
            ST_GAP: begin
               if (smp_bit) begin
                  if (gap_nx > GW'(GAP_MAX)) begin
                     st_n   = ST_IDLE;
                     err_go = 1'b1;
                  end else begin
                     gap_inc = 1'b1;
                  end
               end else begin
                  st_n   = ST_CHAR;
                  ph_clr = 1'b1;
                  sh_clr = 1'b1;
               end
            end
            default: begin
               ph_step = 1'b1;
               if (mid) begin
                  sh_go = 1'b1;
                  if (last) begin
                     if (chr_nx[CHAR_W-1] && !chr_nx[0]) begin
                        byte_go = 1'b1;
                        bcnt_n  = bcnt_inc;
                        if (bcnt_inc == LW'(MAX_BYTES)) begin
                           st_n   = ST_IDLE;
                           err_go = 1'b1;
                        end else begin
                           st_n    = ST_GAP;
                           gap_clr = 1'b1;
                        end
                     end else if (chr_nx == '0) begin
                        st_n    = ST_IDLE;
                        done_go = (bcnt != '0);
                     end else begin
                        st_n   = ST_IDLE;
                        err_go = 1'b1;
                     end
                  end
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st         <= ST_IDLE;
         bcnt       <= '0;
         byte_vld   <= 1'b0;
         byte_data  <= '0;
         frame_done <= 1'b0;
         frame_len  <= '0;
         rx_err     <= 1'b0;
      end else begin
         st         <= st_n;
         bcnt       <= bcnt_n;
         byte_vld   <= byte_go;
         frame_done <= done_go;
         rx_err     <= err_go;
         if (byte_go) byte_data <= chr_nx[DATA_W:1];
         if (done_go) frame_len <= bcnt;
      end
   end

   assign rx_active = (st == ST_GAP) || (st == ST_CHAR);

   // R2: a cycle without a sample produces no event in the next cycle
   a_r2_quiet_without_sample : assert property (@(posedge clk) disable iff (rst)
      !smp_vld |=> !(byte_vld || frame_done || rx_err));
   // R12
   a_r12_done_err_exclusive : assert property (@(posedge clk) disable iff (rst)
      !(frame_done && rx_err));
   a_r8_len_nonzero : assert property (@(posedge clk) disable iff (rst)
      frame_done |-> frame_len != '0);
   a_r11_len_below_max : assert property (@(posedge clk) disable iff (rst)
      frame_done |-> frame_len < LW'(MAX_BYTES));
   a_r3_accept_on_high : assert property (@(posedge clk) disable iff (rst)
      $rose(rx_active) |-> $past(smp_vld && smp_bit));
   a_r9_quiet_exit_on_low : assert property (@(posedge clk) disable iff (rst)
      ($fell(rx_active) && !rx_err) |-> $past(smp_vld && !smp_bit));
   a_r7_byte_from_active : assert property (@(posedge clk) disable iff (rst)
      byte_vld |-> $past(rx_active));
   a_r11_overflow_flags : assert property (@(posedge clk) disable iff (rst)
      (byte_vld && !rx_active) |-> rx_err);
endmodule

// File: tb/cmd_frame_rx_test.sv
`timescale 1ns/1ps
module cmd_frame_rx_test;
   localparam int MAXB = 4;
   localparam int LW   = $clog2(MAXB + 1);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic smp_vld = 1'b0;
   logic smp_bit = 1'b1;
   logic byte_vld, frame_done, rx_err, rx_active;
   logic [7:0] byte_data;
   logic [LW-1:0] frame_len;

   cmd_frame_rx #(.MAX_BYTES(MAXB)) uut (
      .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_bit(smp_bit),
      .byte_vld(byte_vld), .byte_data(byte_data), .frame_done(frame_done),
      .frame_len(frame_len), .rx_err(rx_err), .rx_active(rx_active));

   always #4 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   int idle_sel = 0;
   int idle_force = -1;
   bit finished = 1'b0;

   int m_bytes = 0, m_done = 0, m_err = 0, m_len = 0;
   logic [7:0] m_buf [0:63];

   always @(posedge clk) begin
      #2;
      if (byte_vld) begin
         m_buf[m_bytes % 64] = byte_data;
         m_bytes++;
      end
      if (frame_done) begin
         m_done++;
         m_len = int'(frame_len);
      end
      if (rx_err) m_err++;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic smp(input logic b);
      int n;
      smp_vld = 1'b1;
      smp_bit = b;
      @(negedge clk);
      smp_vld = 1'b0;
      smp_bit = ~b;
      n = (idle_force >= 0) ? idle_force : (idle_sel % 3);
      idle_sel++;
      repeat (n) @(negedge clk);
   endtask

   task automatic samples(input logic b, input int n);
      repeat (n) smp(b);
   endtask

   task automatic bits(input logic b, input int n);
      repeat (n * 4) smp(b);
   endtask

   task automatic sof_pre(input int l);
      samples(1'b1, 4);
      bits(1'b0, l);
      samples(1'b1, 3);
   endtask

   task automatic sof(input int l);
      sof_pre(l);
      samples(1'b1, 1);
   endtask

   task automatic raw_char(input logic [9:0] c, input int extra);
      for (int i = 0; i < 10; i++) bits(c[i], 1);
      samples(1'b1, extra);
   endtask

   task automatic send_byte(input logic [7:0] v, input int extra);
      raw_char({1'b1, v, 1'b0}, extra);
   endtask

   task automatic eof();
      samples(1'b0, 39);
      samples(1'b1, 4);
   endtask

   task automatic do_reset();
      smp_vld = 1'b0;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      int b_by, b_dn, b_er, acc, ok;
      logic [7:0] v;
      @(negedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1 byte_vld", int'(byte_vld), 0);
      chk("R1 frame_done", int'(frame_done), 0);
      chk("R1 rx_err", int'(rx_err), 0);
      chk("R1 rx_active", int'(rx_active), 0);
      do_reset();
      chk("R1 frame_len", int'(frame_len), 0);

      // R3 R4 R5: start-of-frame length sweep
      for (int l = 1; l <= 14; l++) begin
         do_reset();
         b_by = m_bytes; b_dn = m_done; b_er = m_err;
         sof_pre(l);
         acc = (l >= 10 && l <= 12) ? 1 : 0;
         chk(acc ? "R3 sof accept active" : (l > 12 ? "R5 sof long active" : "R4 sof short active"),
             int'(rx_active), acc);
         chk(acc ? "R3 sof accept err" : (l > 12 ? "R5 sof long err" : "R4 sof short err"),
             m_err - b_er, acc ? 0 : (l > 12 ? 2 : 1));
         if (acc) begin
            samples(1'b1, 1);
            send_byte(8'h5A, 2);
            eof();
            chk("R8 single byte frame done", m_done - b_dn, 1);
            chk("R8 single byte len", m_len, 1);
            chk("R7 single byte value", int'(m_buf[b_by % 64]), 'h5A);
         end
      end

      // R1: reset in mid-frame drops active
      do_reset();
      sof(10);
      chk("R3 active after accept", int'(rx_active), 1);
      do_reset();
      chk("R1 reset mid-frame active", int'(rx_active), 0);

      // R7 R8 R2: every byte value, back-to-back frames, varied spacing
      for (int f = 0; f < 86; f++) begin
         b_by = m_bytes; b_dn = m_done; b_er = m_err;
         sof(10 + (f % 3));
         for (int k = 0; k < 3; k++) send_byte(8'((3 * f + k) % 256), (f + k) % 6);
         eof();
         ok = 1;
         for (int k = 0; k < 3; k++)
            if (m_buf[(b_by + k) % 64] != 8'((3 * f + k) % 256)) ok = 0;
         chk("R7 byte sweep values", ok, 1);
         chk("R7 byte sweep count", m_bytes - b_by, 3);
         chk("R8 sweep len", (m_done - b_dn == 1) ? m_len : -1, 3);
         chk("R12 sweep no err", m_err - b_er, 0);
      end

      // R2: long idle stretches with toggling sample value between strobes
      idle_force = 5;
      b_by = m_bytes; b_dn = m_done;
      sof(11);
      send_byte(8'hC3, 1);
      send_byte(8'h18, 0);
      eof();
      idle_force = -1;
      chk("R2 idle stretch bytes", (m_bytes - b_by == 2) ?
          int'({m_buf[b_by % 64], m_buf[(b_by + 1) % 64]}) : -1, 'hC318);
      chk("R2 idle stretch done", m_done - b_dn, 1);

      // R6: gap boundary after start-of-frame
      do_reset();
      b_dn = m_done; b_er = m_err;
      sof(10);
      samples(1'b1, 24);
      send_byte(8'h81, 0);
      eof();
      chk("R6 gap 25 after sof tolerated", (m_err - b_er) * 10 + (m_done - b_dn), 1);
      b_er = m_err;
      sof(10);
      samples(1'b1, 25);
      chk("R6 gap 26 after sof err", m_err - b_er, 1);
      chk("R6 gap 26 after sof active", int'(rx_active), 0);

      // R6: gap boundary between characters
      do_reset();
      b_dn = m_done; b_er = m_err;
      sof(12);
      send_byte(8'h11, 24);
      send_byte(8'h22, 0);
      eof();
      chk("R6 gap 25 between chars len", (m_done - b_dn == 1) ? m_len : -1, 2);
      b_er = m_err; b_dn = m_done;
      sof(12);
      send_byte(8'h33, 25);
      chk("R6 gap 26 between chars err", m_err - b_er, 1);
      chk("R6 gap 26 between chars active", int'(rx_active), 0);

      // R9: empty frame ends silently
      do_reset();
      b_dn = m_done; b_er = m_err;
      sof(10);
      eof();
      chk("R9 empty frame done", m_done - b_dn, 0);
      chk("R9 empty frame err", m_err - b_er, 0);
      chk("R9 empty frame active", int'(rx_active), 0);

      // R10: stop bit low with nonzero data
      do_reset();
      b_dn = m_done; b_er = m_err; b_by = m_bytes;
      sof(10);
      raw_char({1'b0, 8'h01, 1'b0}, 0);
      samples(1'b1, 8);
      chk("R10 bad char err seen", (m_err - b_er >= 1) ? 1 : 0, 1);
      chk("R10 bad char no byte", m_bytes - b_by, 0);
      chk("R10 bad char no done", m_done - b_dn, 0);
      chk("R10 bad char active", int'(rx_active), 0);

      // R11: overflow at MAX_BYTES
      do_reset();
      b_dn = m_done; b_er = m_err; b_by = m_bytes;
      sof(11);
      for (int k = 0; k < MAXB; k++) send_byte(8'hF0 + 8'(k), 1);
      chk("R11 overflow bytes", m_bytes - b_by, MAXB);
      chk("R11 overflow last byte", int'(m_buf[(b_by + MAXB - 1) % 64]), 'hF0 + MAXB - 1);
      chk("R11 overflow err", m_err - b_er, 1);
      chk("R11 overflow no done", m_done - b_dn, 0);
      chk("R11 overflow active", int'(rx_active), 0);

      // R11 boundary: MAX_BYTES-1 bytes complete normally
      b_dn = m_done; b_er = m_err;
      sof(10);
      for (int k = 0; k < MAXB - 1; k++) send_byte(8'h40 + 8'(k), 0);
      eof();
      chk("R11 max-1 frame len", (m_done - b_dn == 1) ? m_len : -1, MAXB - 1);
      chk("R12 max-1 frame no err", m_err - b_er, 0);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
         $finish;
      end
   end
endmodule